// File: doc/BRIEF.md
# Sensor-Triggered Two-Road Signal Controller

This block runs the lights at a crossing of a busy main road and a quiet side road. The main road holds green by default. When the side-road vehicle detector reports a car while the main road is green, the controller issues a one-cycle start pulse to its own interval timer and hands green to the side road on the next clock edge. The side road keeps green until the timer reports expiry, and then control returns to the main road. There are no amber phases.

The sequencer has two named states. `PH_MAJOR` (main green, side red, stored as 0) and `PH_MINOR` (main red, side green, stored as 1) sit in a single register bit that drives the lights directly. The transitions are `MAJOR_HOLD` (in `PH_MAJOR` with no car), `MAJOR_TO_MINOR` (in `PH_MAJOR` with a car), `MINOR_HOLD` (in `PH_MINOR` before expiry) and `MINOR_TO_MAJOR` (in `PH_MINOR` on expiry). The start pulse is a Mealy output: it is asserted in the same cycle in which the detector is sampled. The interval timer is a down-counter of `INTERVAL` cycles. It loads on the start pulse, reloads if a start arrives while it is still counting, and flags expiry for one cycle when it reaches zero.

Top module: `junction_signal_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in `PH_MAJOR`. In the first cycle after reset, `major_green`=1, `minor_green`=0 and, with `car_sense`=0, `start_pulse`=0.
- R2: In `PH_MAJOR` with `car_sense`=0, `start_pulse` stays 0 and the next cycle is again `PH_MAJOR` (`MAJOR_HOLD`).
- R3: In `PH_MAJOR` with `car_sense`=1, `start_pulse` is 1 in that same cycle and the next cycle is `PH_MINOR` (`MAJOR_TO_MINOR`).
- R4: After a start pulse, `minor_green` is 1 for exactly `INTERVAL`+1 consecutive cycles, and then `major_green` returns (`MINOR_TO_MAJOR`).
- R5: In `PH_MINOR` the value of `car_sense` has no effect. `start_pulse` stays 0 and the phase length is unchanged.
- R6: In every cycle exactly one of `major_green` and `minor_green` is 1.
- R7: A car present in the first `PH_MAJOR` cycle after a side-road phase starts a new full side-road phase at once, because the timer is re-armed from idle.
- R8: A reset during `PH_MINOR` returns the controller to `PH_MAJOR` and clears the timer, so no stale expiry occurs. With no car the main road then stays green indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_sense | input | 1 | Side-road vehicle detector, 1 = car waiting |
| major_green | output | 1 | Main road green (side road red) |
| minor_green | output | 1 | Side road green (main road red) |
| start_pulse | output | 1 | One-cycle timer start request, exposed for observation |

## Verification
The assertions assume that `car_sense` is a clean synchronous level that is valid at each sampling edge, and that `rst` is asserted from time zero until after the first edge. The bench changes `car_sense` and `rst` only on falling edges and holds reset high for the first two cycles, so every sampled value is settled. It drives the detector high continuously through a side-road phase to show that the input is ignored there. It also drives a car in the first main-road cycle after expiry and applies a reset in the middle of a side-road phase, so the assumed input discipline still covers these corners.

// File: rtl/jsc_pkg.sv
package jsc_pkg;
    typedef enum logic {
        PH_MAJOR = 1'b0,
        PH_MINOR = 1'b1
    } phase_t;
endpackage

// File: rtl/jsc_interval_timer.sv
module jsc_interval_timer #(
    parameter int INTERVAL = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (INTERVAL < 1) ? 1 : $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(INTERVAL);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= LOAD_VAL;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired = busy_q && (cnt_q == '0);
endmodule

// File: rtl/jsc_sequencer.sv
module jsc_sequencer
    import jsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic car,
    input  logic expired,
    output logic major_on,
    output logic minor_on,
    output logic start
);
    phase_t phase_q, phase_nxt;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_MAJOR;
        else     phase_q <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_MAJOR: phase_nxt = car     ? PH_MINOR : PH_MAJOR;
            PH_MINOR: phase_nxt = expired ? PH_MAJOR : PH_MINOR;
        endcase
    end

    always_comb begin
        major_on = 1'b0;
        minor_on = 1'b0;
        start    = 1'b0;
        unique case (phase_q)
            PH_MAJOR: begin
                major_on = 1'b1;
                start    = car;
            end
            PH_MINOR: begin
                minor_on = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl #(
    parameter int INTERVAL = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic car_sense,
    output logic major_green,
    output logic minor_green,
    output logic start_pulse
);
    logic tmr_expired;
    logic seq_start;

    jsc_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .car      (car_sense),
        .expired  (tmr_expired),
        .major_on (major_green),
        .minor_on (minor_green),
        .start    (seq_start)
    );

    jsc_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (seq_start),
        .expired (tmr_expired)
    );

    assign start_pulse = seq_start;
endmodule

// File: rtl/jsc_checker.sv
module jsc_checker (
    input logic clk,
    input logic rst,
    input logic car,
    input logic major,
    input logic minor,
    input logic start,
    input logic expired
);
    // R6
    one_light_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({major, minor}));

    // R3
    start_in_major_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (major && car));

    // R3
    start_to_minor_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> minor);

    // R2
    major_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (major && !car) |=> major);

    // R5
    minor_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        minor |-> !start);

    // R4
    minor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (minor && !expired) |=> minor);

    // R4
    expiry_ends_minor_chk: assert property (@(posedge clk) disable iff (rst)
        expired |-> minor);

    // R8
    expiry_single_chk: assert property (@(posedge clk) disable iff (rst)
        expired |=> (!expired && major));
endmodule

bind junction_signal_ctrl jsc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .car     (car_sense),
    .major   (major_green),
    .minor   (minor_green),
    .start   (start_pulse),
    .expired (tmr_expired)
);

// File: tb/test_junction_signal_ctrl.sv
module test_junction_signal_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_sense = 1'b0;
    logic major_green, minor_green, start_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] q_exp[$];
    string      q_req[$];

    // reference model state, derived from the requirements
    bit m_minor = 1'b0;
    int m_left  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    junction_signal_ctrl #(.INTERVAL(N)) i_junction_signal_ctrl (
        .clk(clk), .rst(rst), .car_sense(car_sense),
        .major_green(major_green), .minor_green(minor_green),
        .start_pulse(start_pulse)
    );

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        car_sense = 1'b0;
        repeat (cycles) @(negedge clk);
        rst = 1'b0;
        m_minor = 1'b0;
        m_left = 0;
    endtask

    // drive one cycle (called right after a falling edge) and push the expected outputs
    task automatic drive(input bit car, input string req);
        logic [2:0] e;
        car_sense = car;
        e = {!m_minor, m_minor, (!m_minor && car)};
        q_exp.push_back(e);
        q_req.push_back(req);
        if (!m_minor) begin
            if (car) begin
                m_minor = 1'b1;
                m_left = N + 1;
            end
        end else begin
            m_left--;
            if (m_left == 0) m_minor = 1'b0;
        end
        @(negedge clk);
    endtask

    // monitor: scoreboard compare, exclusion check, phase length check
    initial begin
        bit meas = 1'b0;
        int len = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                meas = 1'b0;
                len = 0;
            end else begin
                checks++;
                if ((major_green + minor_green) != 1) begin
                    errors++;
                    $display("FAIL R6: major=%b minor=%b expected exactly one high",
                             major_green, minor_green);
                end
                if (q_exp.size() > 0) begin
                    logic [2:0] e;
                    string r;
                    e = q_exp.pop_front();
                    r = q_req.pop_front();
                    checks++;
                    if ({major_green, minor_green, start_pulse} !== e) begin
                        errors++;
                        $display("FAIL %s: {major,minor,start}=%b expected %b",
                                 r, {major_green, minor_green, start_pulse}, e);
                    end
                end
                if (meas) begin
                    if (minor_green) len++;
                    else begin
                        checks++;
                        if (len != N + 1) begin
                            errors++;
                            $display("FAIL R4: minor phase length %0d expected %0d", len, N + 1);
                        end
                        meas = 1'b0;
                    end
                end
                if (start_pulse && !meas) begin
                    meas = 1'b1;
                    len = 0;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(2);
        drive(1'b0, "R1");                             // R1 reset state
        for (int i = 0; i < 4; i++) drive(1'b0, "R2"); // R2 hold main green
        drive(1'b1, "R3");                             // R3 start pulse
        for (int i = 0; i < N + 1; i++) drive(1'b0, "R4");
        for (int i = 0; i < 3; i++) drive(1'b0, "R2");
        drive(1'b1, "R3");
        for (int i = 0; i < N + 1; i++) drive(1'b1, "R5"); // R5 car ignored in minor
        drive(1'b1, "R7");                             // R7 immediate restart
        for (int i = 0; i < N + 1; i++) drive(1'b0, "R7");
        for (int i = 0; i < 2; i++) drive(1'b0, "R2");
        drive(1'b1, "R3");
        drive(1'b0, "R4");
        drive(1'b0, "R4");
        do_reset(1);                                   // R8 reset mid-phase
        for (int i = 0; i < 2 * N + 4; i++) drive(1'b0, "R8");
        drive(1'b1, "R3");
        for (int i = 0; i < N + 1; i++) drive(1'b0, "R4");
        drive(1'b0, "R2");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule